// File: doc/BRIEF.md
# Triple-Bank Operand Buffer with Stride Sequencer

This block holds the working data of a compute array in three memory banks of equal depth. A run starts with one pulse. The pulse carries a role map that names one bank as the first operand source, one as the second operand source and one as the result sink. It also carries a base address, a word count and a signed stride for each of the three streams. A single sequencer then walks all three streams in lockstep. Its addresses are applied to four replicated lanes, so each lane supplies two 32-bit operand words and absorbs one 32-bit result word per step, each lane working on its own data.

The result stream trails the operand streams by a programmable number of steps, which matches the pipeline depth of the array. A result therefore lands at the address that belongs to its operands. The second operand may be declared unused. That frees one bank, and an external port can then fill or empty it while the run proceeds. An external access to any bank that the running map uses is held off until the run ends. A map that names one bank twice is refused and raises a sticky error flag.

Top module: `tribank_buffer`

## Requirements
- R1: After reset, busy, done, cfg_err, opa_valid, opb_valid and ext_rvalid are low, and ext_gnt is low while ext_req is low.
- R2: Role codes 0, 1 and 2 select a bank. Code 3 means "no bank" and is legal only for the second operand. With code 3 there, no second-operand reads happen and opb_valid stays low.
- R3: The first step of an accepted run is step 0. Operand element k (k < count) is read at step k from address base + k*stride, taken modulo the bank depth of 64. Its word appears on opa_data/opb_data with the matching valid high during step k+1. Valid is low in every other cycle.
- R4: Result element k (k < w_count) is taken from res_data at step w_lat + k. It is written to the sink bank at w_base + k*w_stride modulo 64, in every lane.
- R5: A run lasts T = max(a_count, b_count if the second operand is used, w_lat + w_count if w_count > 0) steps, with busy high for exactly T cycles. done is high for the single cycle that follows. When T = 0, done pulses in the cycle after start and busy never rises.
- R6: A start whose map uses code 3 for the first operand or the sink, or names one bank in two roles, does not run. It sets cfg_err, which stays set until a start is accepted.
- R7: While busy, start is ignored, whatever the configuration: the run length, the map and cfg_err are unchanged.
- R8: An external access to a bank outside the active map (any bank while idle) is granted in the same cycle, even during a run. A write takes effect at that clock edge. Read data appears one cycle later with ext_rvalid high.
- R9: An external access to a bank in the active map is not granted while busy. It is granted in the first cycle in which busy is low.
- R10: Lane i occupies bits [32i+31:32i] of every lane-wide bus. All lanes use the same addresses. An external write changes only the lane selected by ext_lane.
- R11: Strides are 6-bit two's complement values, so negative strides step downward and addresses wrap around both ends of the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Run request pulse |
| cfg_src_a | input | 2 | Bank for first operand |
| cfg_src_b | input | 2 | Bank for second operand, 3 = unused |
| cfg_dst | input | 2 | Bank for results |
| a_base | input | 6 | First operand base address |
| a_count | input | 7 | First operand word count |
| a_stride | input | 6 | First operand signed stride |
| b_base | input | 6 | Second operand base address |
| b_count | input | 7 | Second operand word count |
| b_stride | input | 6 | Second operand signed stride |
| w_base | input | 6 | Result base address |
| w_count | input | 7 | Result word count |
| w_stride | input | 6 | Result signed stride |
| w_lat | input | 4 | Result lag in steps |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start refused |
| opa_valid | output | 1 | First operand words valid |
| opa_data | output | 128 | First operand, four lanes |
| opb_valid | output | 1 | Second operand words valid |
| opb_data | output | 128 | Second operand, four lanes |
| res_data | input | 128 | Result words, four lanes |
| ext_req | input | 1 | External access request |
| ext_we | input | 1 | External write (else read) |
| ext_bank | input | 2 | External target bank |
| ext_lane | input | 2 | External target lane |
| ext_addr | input | 6 | External word address |
| ext_wdata | input | 32 | External write data |
| ext_gnt | output | 1 | External access granted this cycle |
| ext_rvalid | output | 1 | External read data valid |
| ext_rdata | output | 32 | External read data |

## Verification
The compute streams and the external port can act on the banks in the same cycle. The bench provokes this with a run that leaves the second operand unused. During that run it writes and then reads back the free bank, and checks that both accesses are granted at once while operands and results keep flowing. In the same run it holds a request to the sink bank and checks that the grant stays low on every busy cycle and rises exactly in the done cycle. The stored words are then read back and compared with a model that the bench maintains itself. A second overlap, a start pulse with an illegal map arriving mid-run, is judged by an unchanged run length and an unchanged cfg_err.

// File: rtl/tribank_pkg.sv
package tribank_pkg;

    localparam logic [1:0] BANK_NONE = 2'd3;

    typedef struct packed {
        logic [1:0] src_a;
        logic [1:0] src_b;
        logic [1:0] dst;
    } role_map_t;

    // legal: first operand and sink name real, distinct banks; second operand distinct or unused
    function automatic logic map_ok(input role_map_t m);
        if (m.src_a == BANK_NONE || m.dst == BANK_NONE) return 1'b0;
        if (m.src_a == m.dst) return 1'b0;
        if (m.src_b != BANK_NONE && (m.src_b == m.src_a || m.src_b == m.dst)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic bank_in_map(input role_map_t m, input logic [1:0] b);
        return (b == m.src_a) || (b == m.dst) || (m.src_b != BANK_NONE && b == m.src_b);
    endfunction

endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/stride_agen.sv
module stride_agen #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)     addr_d = base;
        else if (adv) addr_d = addr_q + stride;   // modulo bank depth, two's complement stride
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/tribank_buffer.sv
module tribank_buffer
    import tribank_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 32,
    parameter int AW    = 6,
    parameter int LATW  = 4,
    localparam int LW   = AW + 1,
    localparam int LNW  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cfg_src_a,
    input  logic [1:0]         cfg_src_b,
    input  logic [1:0]         cfg_dst,
    input  logic [AW-1:0]      a_base,
    input  logic [LW-1:0]      a_count,
    input  logic [AW-1:0]      a_stride,
    input  logic [AW-1:0]      b_base,
    input  logic [LW-1:0]      b_count,
    input  logic [AW-1:0]      b_stride,
    input  logic [AW-1:0]      w_base,
    input  logic [LW-1:0]      w_count,
    input  logic [AW-1:0]      w_stride,
    input  logic [LATW-1:0]    w_lat,
    output logic               busy,
    output logic               done,
    output logic               cfg_err,
    output logic               opa_valid,
    output logic [LANES*DW-1:0] opa_data,
    output logic               opb_valid,
    output logic [LANES*DW-1:0] opb_data,
    input  logic [LANES*DW-1:0] res_data,
    input  logic               ext_req,
    input  logic               ext_we,
    input  logic [1:0]         ext_bank,
    input  logic [LNW-1:0]     ext_lane,
    input  logic [AW-1:0]      ext_addr,
    input  logic [DW-1:0]      ext_wdata,
    output logic               ext_gnt,
    output logic               ext_rvalid,
    output logic [DW-1:0]      ext_rdata
);
    localparam int CW = ((LW > LATW) ? LW : LATW) + 2;

    typedef struct packed {
        logic            busy;
        logic            done;
        logic            err;
        logic            opa_v;
        logic            opb_v;
        logic            ext_rv;
        role_map_t       map;
        logic [CW-1:0]   step;
        logic [CW-1:0]   total;
        logic [LW-1:0]   a_len;
        logic [LW-1:0]   b_len;
        logic [LW-1:0]   w_len;
        logic [LATW-1:0] lat;
        logic [1:0]      ext_bank;
        logic [LNW-1:0]  ext_lane;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [DW-1:0] pick(input logic [2:0][DW-1:0] v, input logic [1:0] sel);
        case (sel)
            2'd0:    return v[0];
            2'd1:    return v[1];
            2'd2:    return v[2];
            default: return '0;
        endcase
    endfunction

    role_map_t     req_map;
    logic [CW-1:0] len_a_d, len_b_d, len_w_d, req_total;
    logic          start_go, a_act, b_act, w_act, ext_rd_go, ext_wr_go;
    logic [AW-1:0] a_addr, b_addr, w_addr;

    assign req_map = '{src_a: cfg_src_a, src_b: cfg_src_b, dst: cfg_dst};

    always_comb begin
        len_a_d = CW'(a_count);
        len_b_d = (cfg_src_b == BANK_NONE) ? '0 : CW'(b_count);
        len_w_d = (w_count == '0) ? '0 : CW'(w_lat) + CW'(w_count);
        req_total = len_a_d;
        if (len_b_d > req_total) req_total = len_b_d;
        if (len_w_d > req_total) req_total = len_w_d;
    end

    assign start_go = start && !s_q.busy && map_ok(req_map);

    always_comb begin
        a_act = s_q.busy && (s_q.step < CW'(s_q.a_len));
        b_act = s_q.busy && (s_q.map.src_b != BANK_NONE) && (s_q.step < CW'(s_q.b_len));
        w_act = s_q.busy && (s_q.step >= CW'(s_q.lat))
                && ((s_q.step - CW'(s_q.lat)) < CW'(s_q.w_len));
    end

    assign ext_gnt   = ext_req && (ext_bank != BANK_NONE)
                       && !(s_q.busy && bank_in_map(s_q.map, ext_bank));
    assign ext_rd_go = ext_gnt && !ext_we;
    assign ext_wr_go = ext_gnt && ext_we;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.opa_v  = a_act;
        s_d.opb_v  = b_act;
        s_d.ext_rv = ext_rd_go;
        if (ext_rd_go) begin
            s_d.ext_bank = ext_bank;
            s_d.ext_lane = ext_lane;
        end
        if (start && !s_q.busy) begin
            if (map_ok(req_map)) begin
                s_d.err   = 1'b0;
                s_d.map   = req_map;
                s_d.a_len = a_count;
                s_d.b_len = b_count;
                s_d.w_len = w_count;
                s_d.lat   = w_lat;
                s_d.total = req_total;
                s_d.step  = '0;
                if (req_total == '0) s_d.done = 1'b1;
                else                 s_d.busy = 1'b1;
            end else begin
                s_d.err = 1'b1;
            end
        end else if (s_q.busy) begin
            s_d.step = s_q.step + 1'b1;
            if (s_q.step == s_q.total - 1'b1) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    stride_agen #(.AW(AW)) u_agen_a (.clk(clk), .rst_n(rst_n), .load(start_go), .base(a_base),
                                     .adv(a_act), .stride(a_stride), .addr(a_addr));
    stride_agen #(.AW(AW)) u_agen_b (.clk(clk), .rst_n(rst_n), .load(start_go), .base(b_base),
                                     .adv(b_act), .stride(b_stride), .addr(b_addr));
    stride_agen #(.AW(AW)) u_agen_w (.clk(clk), .rst_n(rst_n), .load(start_go), .base(w_base),
                                     .adv(w_act), .stride(w_stride), .addr(w_addr));

    logic [2:0]         bk_re, bk_cwe;
    logic [2:0][AW-1:0] bk_raddr;
    logic [2:0][DW-1:0] rd_all [LANES];

    for (genvar bk = 0; bk < 3; bk++) begin : g_bank
        localparam logic [1:0] BID = 2'(bk);
        assign bk_cwe[bk]   = w_act && (s_q.map.dst == BID);
        assign bk_re[bk]    = (a_act && s_q.map.src_a == BID) || (b_act && s_q.map.src_b == BID)
                              || (ext_rd_go && ext_bank == BID);
        assign bk_raddr[bk] = (a_act && s_q.map.src_a == BID) ? a_addr :
                              (b_act && s_q.map.src_b == BID) ? b_addr : ext_addr;

        // R9
        port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bk_cwe[bk] && ext_wr_go && ext_bank == BID));
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        for (genvar bk = 0; bk < 3; bk++) begin : g_ram
            logic lane_ext_we;
            assign lane_ext_we = ext_wr_go && (ext_bank == 2'(bk)) && (ext_lane == LNW'(ln));
            bank_ram #(.DW(DW), .AW(AW)) u_ram (
                .clk  (clk),
                .we   (bk_cwe[bk] || lane_ext_we),
                .waddr(bk_cwe[bk] ? w_addr : ext_addr),
                .wdata(bk_cwe[bk] ? res_data[ln*DW +: DW] : ext_wdata),
                .re   (bk_re[bk]),
                .raddr(bk_raddr[bk]),
                .rdata(rd_all[ln][bk])
            );
        end
        assign opa_data[ln*DW +: DW] = pick(rd_all[ln], s_q.map.src_a);
        assign opb_data[ln*DW +: DW] = pick(rd_all[ln], s_q.map.src_b);
    end

    assign ext_rdata  = pick(rd_all[s_q.ext_lane], s_q.ext_bank);
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign cfg_err    = s_q.err;
    assign opa_valid  = s_q.opa_v;
    assign opb_valid  = s_q.opb_v;
    assign ext_rvalid = s_q.ext_rv;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !start) |=> !s_q.done);
    // R6
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !s_q.busy && !map_ok(req_map)) |=> (s_q.err && !s_q.busy));
    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.step != s_q.total - 1'b1) |=>
        (s_q.busy && $stable(s_q.map) && $stable(s_q.total) && $stable(s_q.err)));
    // R2
    map_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> map_ok(s_q.map));
    // R3
    opa_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.opa_v) |-> $past(s_q.busy));
endmodule

// File: tb/sim_tribank_buffer.sv
module sim_tribank_buffer;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic start = 1'b0;
    logic [1:0] cfg_src_a = '0, cfg_src_b = '0, cfg_dst = '0;
    logic [5:0] a_base = '0, a_stride = '0, b_base = '0, b_stride = '0, w_base = '0, w_stride = '0;
    logic [6:0] a_count = '0, b_count = '0, w_count = '0;
    logic [3:0] w_lat = '0;
    logic busy, done, cfg_err, opa_valid, opb_valid, ext_gnt, ext_rvalid;
    logic [127:0] opa_data, opb_data;
    logic [127:0] res_data = '0;
    logic ext_req = 1'b0, ext_we = 1'b0;
    logic [1:0] ext_bank = '0, ext_lane = '0;
    logic [5:0] ext_addr = '0;
    logic [31:0] ext_wdata = '0, ext_rdata;

    tribank_buffer u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_dst(cfg_dst),
        .a_base(a_base), .a_count(a_count), .a_stride(a_stride),
        .b_base(b_base), .b_count(b_count), .b_stride(b_stride),
        .w_base(w_base), .w_count(w_count), .w_stride(w_stride), .w_lat(w_lat),
        .busy(busy), .done(done), .cfg_err(cfg_err),
        .opa_valid(opa_valid), .opa_data(opa_data), .opb_valid(opb_valid), .opb_data(opb_data),
        .res_data(res_data),
        .ext_req(ext_req), .ext_we(ext_we), .ext_bank(ext_bank), .ext_lane(ext_lane),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_gnt(ext_gnt), .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata)
    );

    logic [31:0] model [0:3][0:2][0:63];
    int n_tests = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int wrap(input int base, input int stride, input int k);
        return (base + k * stride) & 63;
    endfunction

    function automatic logic [31:0] resv(input int id, input int s, input int ln);
        return 32'hA500_0000 ^ 32'(id << 16) ^ 32'(ln << 8) ^ 32'(s);
    endfunction

    task automatic ext_write(input int bank, input int lane, input int addr, input logic [31:0] d);
        ext_req = 1'b1; ext_we = 1'b1; ext_bank = 2'(bank); ext_lane = 2'(lane);
        ext_addr = 6'(addr); ext_wdata = d;
        #1;
        chk("R8 idle write grant", 32'(ext_gnt), 32'd1);
        model[lane][bank][addr] = d;
        tick();
        ext_req = 1'b0;
    endtask

    task automatic ext_read(input string tag, input int bank, input int lane, input int addr);
        ext_req = 1'b1; ext_we = 1'b0; ext_bank = 2'(bank); ext_lane = 2'(lane); ext_addr = 6'(addr);
        tick();
        ext_req = 1'b0;
        chk({tag, " rvalid"}, 32'(ext_rvalid), 32'd1);
        chk(tag, ext_rdata, model[lane][bank][addr]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 cfg_err", 32'(cfg_err), 0);
        chk("R1 opa_valid", 32'(opa_valid), 0);
        chk("R1 opb_valid", 32'(opb_valid), 0);
        chk("R1 ext_rvalid", 32'(ext_rvalid), 0);
        chk("R1 ext_gnt", 32'(ext_gnt), 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_preload();
        for (int ln = 0; ln < LANES; ln++)
            for (int bk = 0; bk < 3; bk++)
                for (int a = 0; a < 64; a++)
                    ext_write(bk, ln, a, {8'(ln), 8'(bk), 8'h5C, 8'(a)});
        // R10: lane isolation, a single-lane write leaves the other lanes alone
        ext_write(1, 2, 9, 32'hDEAD_0009);
        for (int ln = 0; ln < LANES; ln++) ext_read("R10 lane isolation", 1, ln, 9);
        ext_read("R8 idle readback", 2, 0, 63);
    endtask

    task automatic t_bad_cfg(input int sa, input int sb, input int sd);
        cfg_src_a = 2'(sa); cfg_src_b = 2'(sb); cfg_dst = 2'(sd);
        a_count = 7'd4; w_count = 7'd4;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R6 error set", 32'(cfg_err), 1);
        chk("R6 no busy", 32'(busy), 0);
        chk("R6 no done", 32'(done), 0);
        tick();
        chk("R6 error sticky", 32'(cfg_err), 1);
        chk("R6 still idle", 32'(busy), 0);
    endtask

    task automatic t_zero_run();
        cfg_src_a = 2'd0; cfg_src_b = 2'd3; cfg_dst = 2'd1;
        a_count = '0; b_count = 7'd9; w_count = '0; w_lat = 4'd5;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R5 zero run busy", 32'(busy), 0);
        chk("R5 zero run done", 32'(done), 1);
        tick();
        chk("R5 zero run done drop", 32'(done), 0);
    endtask

    // mode 0: plain, mode 1: external traffic during the run, mode 2: illegal start mid-run
    task automatic do_run(input int id, input int sa, input int sb, input int sd,
                          input int ab, input int as_, input int al,
                          input int bb, input int bs, input int bl,
                          input int wb, input int ws, input int wl,
                          input int lat, input int mode);
        int bt, wt, total, busy_cycles;
        bt = (sb == 3) ? 0 : bl;
        wt = (wl == 0) ? 0 : lat + wl;
        total = al;
        if (bt > total) total = bt;
        if (wt > total) total = wt;
        busy_cycles = 0;
        cfg_src_a = 2'(sa); cfg_src_b = 2'(sb); cfg_dst = 2'(sd);
        a_base = 6'(ab); a_stride = 6'(as_); a_count = 7'(al);
        b_base = 6'(bb); b_stride = 6'(bs); b_count = 7'(bl);
        w_base = 6'(wb); w_stride = 6'(ws); w_count = 7'(wl); w_lat = 4'(lat);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R6 error cleared by accepted start", 32'(cfg_err), 0);
        for (int s = 0; s <= total; s++) begin
            for (int ln = 0; ln < LANES; ln++) res_data[ln*32 +: 32] = resv(id, s, ln);
            if (mode == 2 && s == 1) begin
                start = 1'b1; cfg_dst = cfg_src_a; a_count = 7'd1;
            end
            if (mode == 2 && s == 2) start = 1'b0;
            if (mode == 1) begin
                if (s == 1) begin
                    ext_req = 1'b1; ext_we = 1'b1; ext_bank = 2'd1; ext_lane = 2'd3;
                    ext_addr = 6'd7; ext_wdata = 32'hF00D_0007;
                end else if (s == 2) begin
                    ext_we = 1'b0;
                end else if (s >= 3) begin
                    ext_we = 1'b1; ext_bank = 2'(sd); ext_lane = 2'd0;
                    ext_addr = 6'd30; ext_wdata = 32'hBEEF_0030;
                end
            end
            #1;
            if (s < total) begin
                chk("R5 busy during run", 32'(busy), 1);
                busy_cycles++;
            end else begin
                chk("R5 busy low at end", 32'(busy), 0);
                chk("R5 done pulse", 32'(done), 1);
            end
            if (s >= 1 && s - 1 < al) begin
                chk("R3 opa_valid", 32'(opa_valid), 1);
                for (int ln = 0; ln < LANES; ln++)
                    chk("R3 R10 R11 opa word", opa_data[ln*32 +: 32],
                        model[ln][sa][wrap(ab, as_, s - 1)]);
            end else begin
                chk("R3 opa_valid idle", 32'(opa_valid), 0);
            end
            if (sb != 3 && s >= 1 && s - 1 < bl) begin
                chk("R3 opb_valid", 32'(opb_valid), 1);
                for (int ln = 0; ln < LANES; ln++)
                    chk("R3 R11 opb word", opb_data[ln*32 +: 32],
                        model[ln][sb][wrap(bb, bs, s - 1)]);
            end else begin
                chk("R2 R3 opb_valid idle", 32'(opb_valid), 0);
            end
            if (mode == 1) begin
                if (s == 1) begin
                    chk("R8 free bank write grant while busy", 32'(ext_gnt), 1);
                    model[3][1][7] = 32'hF00D_0007;
                end else if (s == 2) begin
                    chk("R8 free bank read grant while busy", 32'(ext_gnt), 1);
                end else if (s >= 3) begin
                    if (s == 3) begin
                        chk("R8 rvalid while busy", 32'(ext_rvalid), 1);
                        chk("R8 free bank read data", ext_rdata, 32'hF00D_0007);
                    end
                    chk("R9 active bank grant", 32'(ext_gnt), (s == total) ? 1 : 0);
                    if (s == total) model[0][sd][30] = 32'hBEEF_0030;
                end
            end
            if (s >= lat && s - lat < wl)
                for (int ln = 0; ln < LANES; ln++)
                    model[ln][sd][wrap(wb, ws, s - lat)] = resv(id, s, ln);
            tick();
        end
        ext_req = 1'b0;
        start = 1'b0;
        chk("R5 done drops", 32'(done), 0);
        chk("R5 busy cycle count", 32'(busy_cycles), 32'(total));
        if (mode == 2) chk("R7 mid-run start left no error", 32'(cfg_err), 0);
        for (int k = 0; k < wl; k++)
            for (int ln = 0; ln < LANES; ln++)
                ext_read("R4 R10 result placement", sd, ln, wrap(wb, ws, k));
        if (mode == 1) ext_read("R9 stalled write landed", sd, 0, 30);
    endtask

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, no requirement completed");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_preload();
        // R11: second operand walks downward from 2 and wraps to 63
        do_run(1, 0, 1, 2, 3, 2, 8, 2, -1, 10, 10, 1, 8, 2, 0);
        t_bad_cfg(1, 0, 1);
        t_bad_cfg(3, 0, 1);
        // R2: second operand unused, bank 1 free for external traffic
        do_run(2, 2, 3, 0, 40, 5, 6, 0, 0, 0, 60, 3, 6, 4, 1);
        // R7: illegal start pulse arrives mid-run
        do_run(3, 1, 2, 0, 0, 1, 5, 20, 4, 5, 32, -2, 7, 1, 2);
        t_zero_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule